// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block produces the microprogram counter that addresses the control store of a microcoded CPU. On every clock edge it decides where the next microinstruction comes from. The normal case is the next sequential word. The other sources are the first word of the routine for a freshly latched opcode, the start of the instruction-fetch routine when a routine finishes, the target carried by a branch word whose condition holds, or the current word again while the datapath waits for memory.

The fields of the current microinstruction (end marker, branch enable, condition select, branch target and wait-for-memory) come in as plain control pins, and so do the CPU status flags and the memory completion signal. The opcode-to-start-address mapping is a parameter, so each instruction set can place its routines where it needs them. With the default mapping, opcode 6 is the branch-on-negative routine at address 25. All pins are plain level signals sampled once per clock. There is no stream traffic, so there is no back-pressure. The only way to stall is the memory wait described in R3.

Top module: `useq_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0 at that edge, whatever the other inputs are. The first edge after `rst` falls leaves it at 1.
- R2: When no other case applies, `upc` advances by one at each edge, and it wraps from 31 to 0.
- R3: When `mi_wmfc` is 1 and `mem_done` is 0, `upc` keeps its value. When `mi_wmfc` is 1 and `mem_done` is 1, sequencing continues as if no wait had been requested.
- R4: When `mi_end` is 1 and the sequencer is not stalled, `upc` loads the fetch routine address 0. This takes precedence over `ir_load` and over any branch.
- R5: When `ir_load` is 1 (and there is no stall and no end), `upc` loads the start address of `opcode`. The default mapping is opcode k to address 3 for k=0, and 4k+1 for k=1..7. This places opcode 6 at 25 and opcode 7 at 29.
- R6: A dispatch on `ir_load` takes precedence over a branch word in the same cycle.
- R7: When `mi_branch` is 1 and the condition selected by `mi_cond` holds, `upc` loads `mi_target`. The encodings of `mi_cond` are: 2'b00 always; 2'b01 when `flag_n`=0; 2'b10 when `flag_n`=1; 2'b11 when `flag_z`=1.
- R8: When `mi_branch` is 1 and the selected condition fails, `upc` advances by one.
- R9: A memory stall takes precedence over end, dispatch and branch requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_load | input | 1 | Instruction register is being loaded this cycle |
| opcode | input | 3 | Opcode being loaded |
| mi_end | input | 1 | Current word ends its routine |
| mi_branch | input | 1 | Current word is a conditional branch |
| mi_cond | input | 2 | Branch condition select |
| mi_target | input | 5 | Branch target address |
| mi_wmfc | input | 1 | Current word waits for memory completion |
| mem_done | input | 1 | Memory function complete |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| upc | output | 5 | Microprogram counter, control store address |

## Verification
The bench runs a plain fetch followed by a dispatch on three opcodes, including the branch-on-negative routine at 25. This separates a correct mapping from an off-by-one slice. It steps every condition encoding with its flag both true and false, which tells a taken branch apart from the fall-through increment. It then drives end, dispatch and branch requests at the same time, alone and underneath a memory stall, which exposes any swap in the priority order. A jump to 30 followed by two increments shows the wrap-around.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_N_CLR  = 2'b01,
    COND_N_SET  = 2'b10,
    COND_Z_SET  = 2'b11
  } cond_e;

  typedef enum logic [2:0] {
    NXT_HOLD,
    NXT_FETCH,
    NXT_DISPATCH,
    NXT_BRANCH,
    NXT_INC
  } nxt_src_e;
endpackage

// File: rtl/useq_start_map.sv
`timescale 1ns/1ps
module useq_start_map #(
  parameter int OPW = 3,
  parameter int AW  = 5,
  parameter logic [(1<<OPW)*AW-1:0] MAP = '0
) (
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  start_addr
);
  localparam int NOPS = 1 << OPW;

  logic [AW-1:0] entry [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_entry
    assign entry[g] = MAP[g*AW +: AW];
  end

  assign start_addr = entry[opcode];
endmodule

// File: rtl/useq_cond_eval.sv
`timescale 1ns/1ps
module useq_cond_eval
  import useq_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       flag_n,
  input  logic       flag_z,
  output logic       cond_true
);
  always_comb begin
    unique case (cond_e'(cond_sel))
      COND_ALWAYS: cond_true = 1'b1;
      COND_N_CLR:  cond_true = ~flag_n;
      COND_N_SET:  cond_true = flag_n;
      COND_Z_SET:  cond_true = flag_z;
      default:     cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next_sel.sv
`timescale 1ns/1ps
module useq_next_sel
  import useq_pkg::*;
#(
  parameter int AW = 5,
  parameter logic [AW-1:0] FETCH_ADDR = '0
) (
  input  logic [AW-1:0] cur,
  input  logic          stall,
  input  logic          end_req,
  input  logic          load_req,
  input  logic [AW-1:0] dispatch_addr,
  input  logic          br_req,
  input  logic          cond_true,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] nxt
);
  nxt_src_e src;

  always_comb begin
    if (stall)                     src = NXT_HOLD;
    else if (end_req)              src = NXT_FETCH;
    else if (load_req)             src = NXT_DISPATCH;
    else if (br_req && cond_true)  src = NXT_BRANCH;
    else                           src = NXT_INC;
  end

  always_comb begin
    unique case (src)
      NXT_HOLD:     nxt = cur;
      NXT_FETCH:    nxt = FETCH_ADDR;
      NXT_DISPATCH: nxt = dispatch_addr;
      NXT_BRANCH:   nxt = target;
      default:      nxt = cur + AW'(1);
    endcase
  end
endmodule

// File: rtl/useq_seq.sv
`timescale 1ns/1ps
module useq_seq #(
  parameter int OPW = 3,
  parameter int AW  = 5,
  parameter int CW  = 2,
  parameter logic [AW-1:0] FETCH_ADDR = '0,
  parameter logic [(1<<OPW)*AW-1:0] START_MAP =
    {5'd29, 5'd25, 5'd21, 5'd17, 5'd13, 5'd9, 5'd5, 5'd3}
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ir_load,
  input  logic [OPW-1:0] opcode,
  input  logic           mi_end,
  input  logic           mi_branch,
  input  logic [CW-1:0]  mi_cond,
  input  logic [AW-1:0]  mi_target,
  input  logic           mi_wmfc,
  input  logic           mem_done,
  input  logic           flag_n,
  input  logic           flag_z,
  output logic [AW-1:0]  upc
);
  logic [AW-1:0] dispatch_addr;
  logic          cond_true;
  logic [AW-1:0] nxt;
  logic          stall;

  assign stall = mi_wmfc & ~mem_done;

  useq_start_map #(.OPW(OPW), .AW(AW), .MAP(START_MAP)) u_map (
    .opcode     (opcode),
    .start_addr (dispatch_addr)
  );

  useq_cond_eval u_cond (
    .cond_sel  (mi_cond),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .cond_true (cond_true)
  );

  useq_next_sel #(.AW(AW), .FETCH_ADDR(FETCH_ADDR)) u_sel (
    .cur           (upc),
    .stall         (stall),
    .end_req       (mi_end),
    .load_req      (ir_load),
    .dispatch_addr (dispatch_addr),
    .br_req        (mi_branch),
    .cond_true     (cond_true),
    .target        (mi_target),
    .nxt           (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end
endmodule

// File: rtl/useq_seq_chk.sv
`timescale 1ns/1ps
module useq_seq_chk #(
  parameter int OPW = 3,
  parameter int AW  = 5,
  parameter int CW  = 2,
  parameter logic [AW-1:0] FETCH_ADDR = '0,
  parameter logic [(1<<OPW)*AW-1:0] START_MAP = '0
) (
  input logic           clk,
  input logic           rst,
  input logic           ir_load,
  input logic [OPW-1:0] opcode,
  input logic           mi_end,
  input logic           mi_branch,
  input logic [CW-1:0]  mi_cond,
  input logic [AW-1:0]  mi_target,
  input logic           mi_wmfc,
  input logic           mem_done,
  input logic           flag_n,
  input logic           flag_z,
  input logic [AW-1:0]  upc
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  logic hold_in;
  logic quiet;
  logic [AW-1:0] map_of_op;
  assign hold_in   = mi_wmfc & ~mem_done;
  assign quiet     = ~hold_in & ~mi_end & ~ir_load;
  assign map_of_op = START_MAP[opcode*AW +: AW];

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rst) |-> upc == '0);

  // R3, R9
  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && hold_in) |-> upc == $past(upc));

  // R4
  a_r4_end_fetch: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && !hold_in && mi_end) |-> upc == FETCH_ADDR);

  // R5, R6
  a_r5_dispatch: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && !hold_in && !mi_end && ir_load) |-> upc == $past(map_of_op));

  // R2
  a_r2_plain_inc: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && quiet && !mi_branch) |-> upc == $past(upc) + AW'(1));

  // R7
  a_r7_always_taken: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && quiet && mi_branch && mi_cond == 2'b00) |-> upc == $past(mi_target));

  // R8
  a_r8_n_fail_inc: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && quiet && mi_branch && mi_cond == 2'b10 && !flag_n)
    |-> upc == $past(upc) + AW'(1));

  // R7 zero-flag case, R8 zero-flag fall-through
  a_r7_z_select: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!rst && quiet && mi_branch && mi_cond == 2'b11)
    |-> upc == ($past(flag_z) ? $past(mi_target) : $past(upc) + AW'(1)));
endmodule

bind useq_seq useq_seq_chk #(
  .OPW(OPW), .AW(AW), .CW(CW), .FETCH_ADDR(FETCH_ADDR), .START_MAP(START_MAP)
) u_chk (
  .clk(clk), .rst(rst), .ir_load(ir_load), .opcode(opcode), .mi_end(mi_end),
  .mi_branch(mi_branch), .mi_cond(mi_cond), .mi_target(mi_target),
  .mi_wmfc(mi_wmfc), .mem_done(mem_done), .flag_n(flag_n), .flag_z(flag_z),
  .upc(upc)
);

// File: tb/sim_useq_seq.sv
`timescale 1ns/1ps
module sim_useq_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       ir_load;
  logic [2:0] opcode;
  logic       mi_end;
  logic       mi_branch;
  logic [1:0] mi_cond;
  logic [4:0] mi_target;
  logic       mi_wmfc;
  logic       mem_done;
  logic       flag_n;
  logic       flag_z;
  logic [4:0] upc;

  int nchecks = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  useq_seq u0 (
    .clk(clk), .rst(rst), .ir_load(ir_load), .opcode(opcode), .mi_end(mi_end),
    .mi_branch(mi_branch), .mi_cond(mi_cond), .mi_target(mi_target),
    .mi_wmfc(mi_wmfc), .mem_done(mem_done), .flag_n(flag_n), .flag_z(flag_z),
    .upc(upc)
  );

  task automatic idle();
    ir_load = 0; opcode = '0; mi_end = 0; mi_branch = 0; mi_cond = '0;
    mi_target = '0; mi_wmfc = 0; mem_done = 0; flag_n = 0; flag_z = 0;
  endtask

  task automatic tick(input logic [4:0] exp, input string tag);
    @(posedge clk);
    #1;
    nchecks++;
    if (upc !== exp) begin
      nerr++;
      $display("FAIL %s upc=%0d expected=%0d", tag, upc, exp);
    end
    @(negedge clk);
  endtask

  task automatic jump(input logic [4:0] addr);
    idle(); mi_branch = 1; mi_cond = 2'b00; mi_target = addr;
    tick(addr, "R7 always jump");
    idle();
  endtask

  task automatic t_reset();
    idle(); rst = 1; ir_load = 1; opcode = 3'd6; mi_branch = 1; mi_target = 5'd9;
    tick(5'd0, "R1 reset with busy inputs");
    tick(5'd0, "R1 reset held");
    rst = 0; idle();
    tick(5'd1, "R1 first step after reset");
  endtask

  task automatic t_increment();
    tick(5'd2, "R2 inc");
    tick(5'd3, "R2 inc");
    tick(5'd4, "R2 inc");
    jump(5'd30);
    tick(5'd31, "R2 inc to top");
    tick(5'd0, "R2 wrap");
  endtask

  task automatic t_dispatch();
    tick(5'd1, "R2 fetch word");
    tick(5'd2, "R2 fetch word");
    ir_load = 1; opcode = 3'd6;
    tick(5'd25, "R5 opcode 6");
    idle(); mi_end = 1;
    tick(5'd0, "R4 end");
    idle(); ir_load = 1; opcode = 3'd0;
    tick(5'd3, "R5 opcode 0");
    opcode = 3'd7;
    tick(5'd29, "R5 opcode 7");
    idle();
  endtask

  task automatic t_jmpn();
    jump(5'd25);
    mi_branch = 1; mi_cond = 2'b01; mi_target = 5'd0; flag_n = 0;
    tick(5'd0, "R7 N clear taken");
    jump(5'd25);
    mi_branch = 1; mi_cond = 2'b01; mi_target = 5'd0; flag_n = 1;
    tick(5'd26, "R8 N set falls through");
    idle();
    tick(5'd27, "R2 routine body");
    mi_end = 1;
    tick(5'd0, "R4 routine end");
    idle();
  endtask

  task automatic t_conds();
    mi_branch = 1; mi_cond = 2'b10; flag_n = 1; mi_target = 5'd12;
    tick(5'd12, "R7 N set taken");
    flag_n = 0; mi_target = 5'd20;
    tick(5'd13, "R8 N set not taken");
    mi_cond = 2'b11; flag_z = 1; mi_target = 5'd7;
    tick(5'd7, "R7 Z taken");
    flag_z = 0; mi_target = 5'd20;
    tick(5'd8, "R8 Z not taken");
    mi_cond = 2'b01; flag_z = 1; flag_n = 0; mi_target = 5'd4;
    tick(5'd4, "R7 N clear ignores Z");
    idle();
  endtask

  task automatic t_stall();
    mi_wmfc = 1; mem_done = 0;
    tick(5'd4, "R3 hold");
    tick(5'd4, "R3 hold again");
    mi_end = 1; ir_load = 1; opcode = 3'd2; mi_branch = 1; mi_target = 5'd17;
    tick(5'd4, "R9 stall beats end/load/branch");
    idle(); mi_wmfc = 1; mem_done = 1;
    tick(5'd5, "R3 released");
    idle();
  endtask

  task automatic t_prio();
    mi_end = 1; ir_load = 1; opcode = 3'd3; mi_branch = 1; mi_target = 5'd17;
    tick(5'd0, "R4 end beats load and branch");
    idle(); ir_load = 1; opcode = 3'd1; mi_branch = 1; mi_target = 5'd17;
    tick(5'd5, "R6 dispatch beats branch");
    idle();
  endtask

  initial begin
    rst = 1; idle();
    @(negedge clk);
    t_reset();
    t_increment();
    t_dispatch();
    t_jmpn();
    t_conds();
    t_stall();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule